// File: doc/BRIEF.md
# Lease-Based Allocation Unit Manager

The block keeps a small table of allocation units. Each unit records the process that owns it and how many activations of that process its lease still has left. A unit whose remaining lease is zero is free. A process asks for a number of units together with an expiration. The block answers on the next cycle with a grant or a reject. A grant also names the lowest-numbered unit it handed out, and that unit becomes the process's selector. Only one allocation per process may be live at a time.

Ownership fades on its own. Every activation tick for a process ages that process's leases, and a lease that reaches zero returns its unit to the pool. A process keeps its units by sending extend commands, and it can release them at once with a free command. A background walker visits one unit per cycle. It frees any unit whose lease is out of range or whose owner number does not name a process. It also visits one process per cycle and drops that process's selector once the process owns nothing. The free count is rebuilt from the table on every cycle rather than kept as a running tally. Because of this, any table contents, however they were reached, settle to a consistent state in which only recently requested units stay owned.

Top module: `lease_alloc`

## Requirements
- R1: After reset no response is asserted and the free count equals UNITS (8).
- R2: An allocate command (cmd=1) from a valid process that holds no selector, with 1 <= quantity <= free count, raises rsp_grant one cycle later. It takes the lowest-indexed free units, reports the lowest of them on rsp_unit, and lowers the free count by the quantity in that same cycle.
- R3: An allocate with quantity 0 or quantity above the free count raises rsp_reject one cycle later and changes nothing.
- R4: An allocate from a process that already holds a selector is rejected.
- R5: An allocate naming a process number >= PROCS (3) is rejected.
- R6: A tick command (cmd=4) lowers by one the lease of every unit held by the named process. A unit is freed on the tick that brings its lease to zero. Ticks for other processes leave it untouched.
- R7: An expiration of 0 is taken as 1, and an expiration above LEASE_MAX (5) is taken as LEASE_MAX.
- R8: An extend command (cmd=3) sets the lease of every unit held by the process to the clamped expiration.
- R9: A free command (cmd=2) releases all units of the process and drops its selector at once, so an allocate on the very next cycle can be granted.
- R10: Once a process's last unit expires, its selector is dropped within PROCS cycles. The walker keeps every owned unit's lease within 1..LEASE_MAX and its owner below PROCS.
- R11: Idle (cmd=0) and unused codes (5..7) give no response and leave the table and free count unchanged.
- R12: The free count always equals the number of units with zero lease and never exceeds UNITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 idle, 1 allocate, 2 free, 3 extend, 4 tick |
| cmd_proc | input | PW (2) | Process the command refers to |
| cmd_qty | input | CW (4) | Units requested by an allocate |
| cmd_exp | input | LW (3) | Requested expiration in activations |
| rsp_grant | output | 1 | Allocate granted (one-cycle pulse) |
| rsp_reject | output | 1 | Allocate rejected (one-cycle pulse) |
| rsp_unit | output | UW (3) | Lowest unit handed out by the grant |
| free_cnt | output | CW (4) | Units currently free |

## Verification
A stale or wrong lease shows up at the ports as a free count that rises too early or too late in a tick sequence. It appears on the cycle after the tick where the bench's arithmetic expects the change. A wrong owner or a missed scan position shows up on the next grant as a wrong rsp_unit or a wrong drop in the free count. A selector that is never dropped shows up as a reject of a request made PROCS cycles after expiry. The sweeps cover every quantity from 0 past the table size, every expiration code, and tick counts up to full expiry. So each fault becomes visible within one command of its cause.

// File: rtl/lease_alloc.sv
module lease_alloc #(
  parameter int UNITS     = 8,
  parameter int PROCS     = 3,
  parameter int LEASE_MAX = 5,
  localparam int UW = $clog2(UNITS),
  localparam int CW = $clog2(UNITS + 1),
  localparam int PW = $clog2(PROCS + 1),
  localparam int LW = $clog2(LEASE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [PW-1:0] cmd_proc,
  input  logic [CW-1:0] cmd_qty,
  input  logic [LW-1:0] cmd_exp,
  output logic          rsp_grant,
  output logic          rsp_reject,
  output logic [UW-1:0] rsp_unit,
  output logic [CW-1:0] free_cnt
);

  logic [UNITS-1:0][PW-1:0] owner_q, owner_n;
  logic [UNITS-1:0][LW-1:0] lease_q, lease_n;
  logic [PROCS-1:0]         selv_q, selv_n;
  logic [PROCS-1:0][UW-1:0] sel_q, sel_n;
  logic [UW-1:0]            vp_q;
  logic [PW-1:0]            pp_q;
  logic [CW-1:0]            fc_n, taken;
  logic [UW-1:0]            first;
  logic                     found, held, owns;

  wire is_alloc  = cmd == 3'd1;
  wire is_free   = cmd == 3'd2;
  wire is_extend = cmd == 3'd3;
  wire is_tick   = cmd == 3'd4;
  wire proc_ok   = cmd_proc < PW'(PROCS);

  wire [LW-1:0] exp_c = (cmd_exp == '0) ? LW'(1) :
                        (cmd_exp > LW'(LEASE_MAX)) ? LW'(LEASE_MAX) : cmd_exp;

  always_comb begin
    held = 1'b0;
    for (int p = 0; p < PROCS; p++)
      if (cmd_proc == PW'(p)) held = selv_q[p];
  end

  wire alloc_ok = is_alloc && proc_ok && !held &&
                  cmd_qty != '0 && cmd_qty <= free_cnt;

  always_comb begin
    owner_n = owner_q;
    lease_n = lease_q;
    sel_n   = sel_q;
    selv_n  = selv_q;
    taken   = '0;
    first   = '0;
    found   = 1'b0;

    for (int u = 0; u < UNITS; u++) begin
      if (alloc_ok && lease_q[u] == '0 && taken < cmd_qty) begin
        owner_n[u] = cmd_proc;
        lease_n[u] = exp_c;
        if (!found) first = UW'(u);
        found = 1'b1;
        taken = taken + 1'b1;
      end else if (proc_ok && lease_q[u] != '0 && owner_q[u] == cmd_proc) begin
        if (is_free)        lease_n[u] = '0;
        else if (is_extend) lease_n[u] = exp_c;
        else if (is_tick)   lease_n[u] = lease_q[u] - 1'b1;
      end
    end

    for (int p = 0; p < PROCS; p++) begin
      if (cmd_proc == PW'(p)) begin
        if (alloc_ok) begin
          selv_n[p] = 1'b1;
          sel_n[p]  = first;
        end else if (is_free) begin
          selv_n[p] = 1'b0;
        end
      end
    end

    if (lease_n[vp_q] > LW'(LEASE_MAX) || owner_n[vp_q] >= PW'(PROCS))
      lease_n[vp_q] = '0;

    owns = 1'b0;
    for (int u = 0; u < UNITS; u++)
      if (lease_n[u] != '0 && owner_n[u] == pp_q) owns = 1'b1;
    for (int p = 0; p < PROCS; p++)
      if (pp_q == PW'(p) && !owns) selv_n[p] = 1'b0;

    fc_n = '0;
    for (int u = 0; u < UNITS; u++)
      fc_n = fc_n + {{(CW-1){1'b0}}, lease_n[u] == '0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q    <= '0;
      lease_q    <= '0;
      selv_q     <= '0;
      sel_q      <= '0;
      vp_q       <= '0;
      pp_q       <= '0;
      free_cnt   <= CW'(UNITS);
      rsp_grant  <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_unit   <= '0;
    end else begin
      owner_q    <= owner_n;
      lease_q    <= lease_n;
      selv_q     <= selv_n;
      sel_q      <= sel_n;
      vp_q       <= (vp_q == UW'(UNITS - 1)) ? '0 : vp_q + 1'b1;
      pp_q       <= (pp_q >= PW'(PROCS - 1)) ? '0 : pp_q + 1'b1;
      free_cnt   <= fc_n;
      rsp_grant  <= alloc_ok;
      rsp_reject <= is_alloc && !alloc_ok;
      rsp_unit   <= first;
    end
  end

endmodule

// File: rtl/lease_alloc_chk.sv
module lease_alloc_chk #(
  parameter int UNITS     = 8,
  parameter int PROCS     = 3,
  parameter int LEASE_MAX = 5,
  localparam int CW = $clog2(UNITS + 1),
  localparam int PW = $clog2(PROCS + 1),
  localparam int LW = $clog2(LEASE_MAX + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [2:0]               cmd,
  input logic [PW-1:0]            cmd_proc,
  input logic [CW-1:0]            cmd_qty,
  input logic                     rsp_grant,
  input logic                     rsp_reject,
  input logic [CW-1:0]            free_cnt,
  input logic [UNITS-1:0][PW-1:0] owner,
  input logic [UNITS-1:0][LW-1:0] lease
);

  p_free_bound_r12: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CW'(UNITS));

  p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_grant, rsp_reject}));

  p_grant_drop_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> free_cnt == $past(free_cnt) - $past(cmd_qty));

  p_full_reject_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == 3'd1 && $past(cmd_qty) > $past(free_cnt)) |-> rsp_reject);

  p_bad_proc_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == 3'd1 && $past(cmd_proc) >= PW'(PROCS)) |-> rsp_reject);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) != 3'd1) |-> (!rsp_grant && !rsp_reject));

  p_idle_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == 3'd0 && $past(cmd, 2) == 3'd0 && !$past(rst))
      |-> $stable(free_cnt));

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int u = 0; u < UNITS; u++)
        p_table_sane_r10: assert (lease[u] == '0 ||
          (lease[u] <= LW'(LEASE_MAX) && owner[u] < PW'(PROCS)));
    end
  end

endmodule

bind lease_alloc lease_alloc_chk #(
  .UNITS(UNITS), .PROCS(PROCS), .LEASE_MAX(LEASE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cmd_proc(cmd_proc), .cmd_qty(cmd_qty),
  .rsp_grant(rsp_grant), .rsp_reject(rsp_reject), .free_cnt(free_cnt),
  .owner(owner_q), .lease(lease_q)
);

// File: tb/lease_alloc_test.sv
module lease_alloc_test;
  localparam int UNITS = 8, PROCS = 3, LMAX = 5;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = '0;
  logic [1:0] cmd_proc = '0;
  logic [3:0] cmd_qty = '0;
  logic [2:0] cmd_exp = '0;
  logic       rsp_grant, rsp_reject;
  logic [2:0] rsp_unit;
  logic [3:0] free_cnt;

  lease_alloc uut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int mlease[UNITS];
  int mowner[UNITS];
  bit msel[PROCS];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mfree();
    int n = 0;
    for (int u = 0; u < UNITS; u++) if (mlease[u] == 0) n++;
    return n;
  endfunction

  function automatic int clampx(input int e);
    return (e == 0) ? 1 : (e > LMAX ? LMAX : e);
  endfunction

  task automatic settle();
    repeat (PROCS + 1) begin
      @(negedge clk);
      check(!rsp_grant && !rsp_reject, "R11", rsp_grant, 0);
    end
    for (int p = 0; p < PROCS; p++) begin
      bit any = 0;
      for (int u = 0; u < UNITS; u++) if (mlease[u] != 0 && mowner[u] == p) any = 1;
      if (!any) msel[p] = 0;
    end
  endtask

  task automatic apply(input int c, input int p, input int q, input int e, input string tag);
    bit eg = 0, er = 0;
    int eu = 0, taken = 0;
    if (c == 1) begin
      eg = (p < PROCS) && !msel[p] && q != 0 && q <= mfree();
      er = !eg;
      if (eg) begin
        for (int u = UNITS - 1; u >= 0; u--) if (mlease[u] == 0) eu = u;
        for (int u = 0; u < UNITS; u++)
          if (mlease[u] == 0 && taken < q) begin
            mlease[u] = clampx(e); mowner[u] = p; taken++;
          end
        msel[p] = 1;
      end
    end else if (c >= 2 && c <= 4 && p < PROCS) begin
      for (int u = 0; u < UNITS; u++)
        if (mlease[u] != 0 && mowner[u] == p) begin
          if (c == 2) mlease[u] = 0;
          else if (c == 3) mlease[u] = clampx(e);
          else mlease[u] = mlease[u] - 1;
        end
      if (c == 2) msel[p] = 0;
    end
    @(negedge clk);
    cmd = 3'(c); cmd_proc = 2'(p); cmd_qty = 4'(q); cmd_exp = 3'(e);
    @(posedge clk);
    #1;
    cmd = '0;
    check(rsp_grant == eg, tag, rsp_grant, eg);
    check(rsp_reject == er, tag, rsp_reject, er);
    if (eg) check(rsp_unit == 3'(eu), tag, rsp_unit, eu);
    check(free_cnt == 4'(mfree()), "R12", free_cnt, mfree());
    if (c == 4) settle();
  endtask

  task automatic clear_all();
    for (int p = 0; p < PROCS; p++) apply(2, p, 0, 0, "R9");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < UNITS; u++) begin mlease[u] = 0; mowner[u] = 0; end
    for (int p = 0; p < PROCS; p++) msel[p] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!rsp_grant && !rsp_reject, "R1", rsp_grant, 0);
    check(free_cnt == 4'(UNITS), "R1", free_cnt, UNITS);

    // R2 / R3: every quantity from zero past the table size
    for (int q = 0; q <= UNITS + 2; q++) begin
      apply(1, 0, q, 3, (q == 0 || q > UNITS) ? "R3" : "R2");
      apply(2, 0, 0, 0, "R9");
    end

    // R5: out-of-range process numbers
    apply(1, 3, 1, 2, "R5");

    // R4: second request while holding
    apply(1, 0, 2, 3, "R2");
    apply(1, 0, 1, 3, "R4");

    // fragmented pool
    apply(1, 1, 3, 5, "R2");
    apply(1, 2, 2, 1, "R2");
    apply(2, 0, 0, 0, "R9");
    apply(1, 0, 3, 4, "R9");
    apply(1, 2, 1, 2, "R4");
    apply(2, 2, 0, 0, "R9");
    apply(1, 2, 4, 2, "R3");
    apply(1, 2, 2, 2, "R2");

    // R6: aging only by owner's ticks
    apply(4, 2, 0, 0, "R6");
    for (int k = 0; k < 5; k++) apply(4, 1, 0, 0, "R6");
    apply(1, 1, 1, 3, "R10");
    clear_all();

    // R7: every expiration code, aged to expiry
    for (int e = 0; e < 8; e++) begin
      apply(1, 2, 1, e, "R7");
      for (int k = 0; k < clampx(e); k++) apply(4, 2, 0, 0, "R7");
      apply(1, 2, 2, e, "R10");
      apply(2, 2, 0, 0, "R9");
    end

    // R8: extend renews
    apply(1, 0, 2, 2, "R2");
    apply(4, 0, 0, 0, "R6");
    apply(3, 0, 0, 4, "R8");
    for (int k = 0; k < 4; k++) apply(4, 0, 0, 0, "R8");
    apply(1, 1, 3, 7, "R2");
    apply(3, 1, 0, 0, "R8");
    apply(4, 1, 0, 0, "R8");

    // R11: idle and unused codes
    apply(1, 2, 2, 5, "R2");
    for (int c = 5; c < 8; c++) apply(c, 2, 3, 1, "R11");
    apply(0, 2, 3, 1, "R11");
    apply(1, 2, 1, 1, "R4");
    clear_all();
    apply(1, 1, UNITS, 3, "R2");
    apply(1, 0, 1, 3, "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule